// File: doc/BRIEF.md
# Disk Attachment Command Issue Sequencer

This block is the host-side engine that hands one command to a disk attachment over a small register interface. The attachment has a control register, an attention register and a command word register. A caller supplies an attention type, a target device number and the command itself. The command is either a generic one, made of a code, an option byte and two or four words, or a block transfer described by a block count and a cylinder/head/sector address. The caller pulses `start`, and the sequencer does the rest.

The sequencer first runs the attention handshake. It masks the attachment interrupt, waits for the attachment to leave its busy state, writes the attention byte and then unmasks the interrupt. For a command request it then pushes the words into the command register one at a time. After each word it waits for the register-full status to drop. It then waits for a completion indication inside a bounded window and reports the outcome.

Every wait is bounded. A busy attachment, a command word that is never taken and a completion that never arrives all end in an error pulse with a code. The sequencer never hangs.

Top module: `dsk_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `reg_wr` are 0 and `err_code` is 0.
- R2: An operation writes the control register (`reg_sel`=0) with 0x00, then the attention register (`reg_sel`=1) with {device[2:0] in bits 7:5, attention type in bits 4:0}, then the control register with 0x01 (bit 0 = interrupt enable). Each write is a one-cycle `reg_wr` strobe.
- R3: The busy poll tolerates up to POLL_LIMIT-1 busy samples. On the POLL_LIMIT-th busy sample the operation ends with `err` and `err_code`=1, and the attention register is never written.
- R4: When `skip_busy` is 1 (acknowledging a reset-completed event), `att_busy` is not sampled at all.
- R5: An attention type other than 1 (command request) completes with `done` right after the enabling control write, and no command word is written.
- R6: For a command request, the first word (`reg_sel`=2) is {options[7:0] in 15:8, device in 7:5, code in 4:0}, with bit 14 forced to 1 when `long_cmd`=1. A short command then sends `arg1`. A long command sends `arg1`, `arg2` and `arg3`, in that order.
- R7: With `xfer_mode`=1 the command is always four words. The options are 2. Word 1 is the block count, word 2 is cyl[4:0]<<11 | head<<5 | sector, and word 3 is cyl[9:5].
- R8: No command word is written until the previous one is taken (`cmd_full` low). On the POLL_LIMIT-th full sample the operation ends with `err_code`=2, and no further word is written.
- R9: After the last word, `comp_valid` with `comp_ok`=1 ends with `done` and `err_code`=0. With `comp_ok`=0 it ends with `err` and `err_code`=3.
- R10: The completion window is TICK_DIV*TIMEOUT_TICKS cycles. A completion seen in the last cycle of the window is accepted. One cycle later, expiry wins and the operation ends with `err_code`=3.
- R11: `start` is taken only when idle and is ignored while `busy`. `busy` rises the cycle after acceptance and falls in the cycle of the one-cycle `done`/`err` pulse. `done`, `err` and `busy` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (idle only) |
| attn_type | input | 5 | Attention type, 1 = command request |
| skip_busy | input | 1 | Skip the busy poll |
| dev_num | input | 3 | Target device number |
| cmd_code | input | 5 | Command code |
| opts | input | 8 | Option byte (generic commands) |
| long_cmd | input | 1 | 1 = four-word command |
| arg1 | input | 16 | Command word 1 |
| arg2 | input | 16 | Command word 2 |
| arg3 | input | 16 | Command word 3 |
| xfer_mode | input | 1 | Build a block transfer command |
| blk_count | input | 16 | Blocks to move (transfer mode) |
| cyl | input | 10 | Cylinder (transfer mode) |
| head | input | 6 | Head (transfer mode) |
| sector | input | 5 | Sector (transfer mode) |
| reg_wr | output | 1 | Register write strobe |
| reg_sel | output | 2 | 0 control, 1 attention, 2 command word |
| reg_wdata | output | 16 | Write data |
| att_busy | input | 1 | Attachment busy status |
| cmd_full | input | 1 | Command register still full |
| comp_valid | input | 1 | Completion indication |
| comp_ok | input | 1 | Completion status is success |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Success pulse |
| err | output | 1 | Failure pulse |
| err_code | output | 2 | 1 busy timeout, 2 word stuck, 3 completion failure |

## Verification
The bench builds the block with POLL_LIMIT=5, TICK_DIV=3 and TIMEOUT_TICKS=4, so every bound becomes a short run. The busy and full polls can be driven to exactly one sample below their limit and exactly to it. The twelve-cycle completion window can be hit on its last accepted cycle and on the first rejected one. With these small values, the bench can also sweep all eight device numbers, both command lengths, several codes and option bytes, and a grid of cylinder, head and sector values. It checks every register write of each run against words it packs itself.

// File: rtl/dsk_cmd_pkg.sv
package dsk_cmd_pkg;

    localparam int WORD_W    = 16;
    localparam int WORDS_MAX = 4;
    localparam int WIDX_W    = $clog2(WORDS_MAX);
    localparam int DEV_W     = 3;
    localparam int CODE_W    = 5;
    localparam int OPT_W     = 8;
    localparam int CYL_W     = 10;
    localparam int CYL_LO_W  = 5;
    localparam int HEAD_W    = 6;
    localparam int SEC_W     = 5;

    localparam logic [OPT_W-1:0]  XFER_OPTS    = 8'd2;
    localparam logic [WORD_W-1:0] LONG_FLAG    = 16'h4000;
    localparam logic [7:0]        CTRL_IRQ_EN  = 8'h01;
    localparam logic [CODE_W-1:0] ATTN_CMD_REQ = 5'd1;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_ATTN = 2'd1,
        REG_CMDW = 2'd2
    } reg_sel_e;

    typedef enum logic [1:0] {
        ERR_NONE       = 2'd0,
        ERR_ATTN_BUSY  = 2'd1,
        ERR_WORD_STUCK = 2'd2,
        ERR_COMPLETION = 2'd3
    } err_code_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_IRQ_OFF,
        S_POLL_BUSY,
        S_ATTN,
        S_IRQ_ON,
        S_WORD,
        S_SETTLE,
        S_POLL_FULL,
        S_WAIT_DONE
    } seq_state_e;

    typedef logic [WORDS_MAX-1:0][WORD_W-1:0] cmd_words_t;

    typedef struct packed {
        seq_state_e        st;
        cmd_words_t        words;
        logic              four;
        logic [WIDX_W-1:0] widx;
        logic [DEV_W-1:0]  dev;
        logic [CODE_W-1:0] atype;
        logic              skip;
        logic              wr;
        reg_sel_e          sel;
        logic [WORD_W-1:0] wdata;
        logic              busy;
        logic              done;
        logic              err;
        err_code_e         ecode;
    } seq_regs_t;

endpackage

// File: rtl/dsk_cmd_pack.sv
module dsk_cmd_pack
    import dsk_cmd_pkg::*;
(
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [DEV_W-1:0]  dev_num,
    input  logic [OPT_W-1:0]  opts,
    input  logic              long_cmd,
    input  logic [WORD_W-1:0] arg1,
    input  logic [WORD_W-1:0] arg2,
    input  logic [WORD_W-1:0] arg3,
    input  logic              xfer_mode,
    input  logic [WORD_W-1:0] blk_count,
    input  logic [CYL_W-1:0]  cyl,
    input  logic [HEAD_W-1:0] head,
    input  logic [SEC_W-1:0]  sector,
    output cmd_words_t        words,
    output logic              four_words
);
    localparam int CYL_HI_W = CYL_W - CYL_LO_W;

    logic [OPT_W-1:0] opt_eff;

    always_comb begin
        four_words = xfer_mode | long_cmd;
        opt_eff    = xfer_mode ? XFER_OPTS : opts;
        // header: options high byte, device above the code
        words[0]   = {opt_eff, dev_num, cmd_code} | (four_words ? LONG_FLAG : '0);
        if (xfer_mode) begin
            words[1] = blk_count;
            words[2] = {cyl[CYL_LO_W-1:0], head, sector};
            words[3] = {{(WORD_W-CYL_HI_W){1'b0}}, cyl[CYL_W-1:CYL_LO_W]};
        end else begin
            words[1] = arg1;
            words[2] = arg2;
            words[3] = arg3;
        end
    end
endmodule

// File: rtl/dsk_poll_ctr.sv
module dsk_poll_ctr #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hit,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        last = (cnt_q == CW'(LIMIT - 1));
        if (!run)
            cnt_d = '0;
        else if (hit && !last)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dsk_wait_timer.sv
module dsk_wait_timer #(
    parameter int TICK_DIV      = 100_000_000,
    parameter int TIMEOUT_TICKS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int PW = $clog2(TICK_DIV + 1);
    localparam int TW = $clog2(TIMEOUT_TICKS + 1);

    logic [PW-1:0] pre_d, pre_q;
    logic [TW-1:0] tick_d, tick_q;

    always_comb begin
        expired = (tick_q == TW'(TIMEOUT_TICKS));
        pre_d   = pre_q;
        tick_d  = tick_q;
        if (!run) begin
            pre_d  = '0;
            tick_d = '0;
        end else if (!expired) begin
            if (pre_q == PW'(TICK_DIV - 1)) begin
                pre_d  = '0;
                tick_d = tick_q + 1'b1;
            end else begin
                pre_d  = pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else begin
            pre_q  <= pre_d;
            tick_q <= tick_d;
        end
    end
endmodule

// File: rtl/dsk_cmd_seq.sv
module dsk_cmd_seq
    import dsk_cmd_pkg::*;
#(
    parameter int POLL_LIMIT    = 10000,
    parameter int TICK_DIV      = 100_000_000,
    parameter int TIMEOUT_TICKS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] attn_type,
    input  logic              skip_busy,
    input  logic [DEV_W-1:0]  dev_num,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [OPT_W-1:0]  opts,
    input  logic              long_cmd,
    input  logic [WORD_W-1:0] arg1,
    input  logic [WORD_W-1:0] arg2,
    input  logic [WORD_W-1:0] arg3,
    input  logic              xfer_mode,
    input  logic [WORD_W-1:0] blk_count,
    input  logic [CYL_W-1:0]  cyl,
    input  logic [HEAD_W-1:0] head,
    input  logic [SEC_W-1:0]  sector,
    output logic              reg_wr,
    output logic [1:0]        reg_sel,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic              att_busy,
    input  logic              cmd_full,
    input  logic              comp_valid,
    input  logic              comp_ok,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code
);
    seq_regs_t  r_d, r_q;
    cmd_words_t pk_words;
    logic       pk_four;
    logic       poll_run, poll_hit, poll_last;
    logic       win_run, win_expired;
    logic [WIDX_W-1:0] last_idx;

    dsk_cmd_pack u_pack (
        .cmd_code  (cmd_code),
        .dev_num   (dev_num),
        .opts      (opts),
        .long_cmd  (long_cmd),
        .arg1      (arg1),
        .arg2      (arg2),
        .arg3      (arg3),
        .xfer_mode (xfer_mode),
        .blk_count (blk_count),
        .cyl       (cyl),
        .head      (head),
        .sector    (sector),
        .words     (pk_words),
        .four_words(pk_four)
    );

    // one retry counter serves both polls; they are never adjacent
    assign poll_run = (r_q.st == S_POLL_BUSY) || (r_q.st == S_POLL_FULL);
    assign poll_hit = (r_q.st == S_POLL_BUSY) ? att_busy : cmd_full;

    dsk_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (poll_run),
        .hit  (poll_hit),
        .last (poll_last)
    );

    assign win_run = (r_q.st == S_WAIT_DONE);

    dsk_wait_timer #(
        .TICK_DIV     (TICK_DIV),
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (win_run),
        .expired(win_expired)
    );

    assign last_idx = r_q.four ? WIDX_W'(WORDS_MAX - 1) : WIDX_W'(1);

    always_comb begin
        r_d      = r_q;
        r_d.wr   = 1'b0;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.words = pk_words;
                    r_d.four  = pk_four;
                    r_d.dev   = dev_num;
                    r_d.atype = attn_type;
                    r_d.skip  = skip_busy;
                    r_d.busy  = 1'b1;
                    r_d.ecode = ERR_NONE;
                    r_d.st    = S_IRQ_OFF;
                end
            end
            S_IRQ_OFF: begin
                r_d.wr    = 1'b1;
                r_d.sel   = REG_CTRL;
                r_d.wdata = '0;
                r_d.st    = r_q.skip ? S_ATTN : S_POLL_BUSY;
            end
            S_POLL_BUSY: begin
                if (!att_busy) begin
                    r_d.st = S_ATTN;
                end else if (poll_last) begin
                    r_d.st    = S_IDLE;
                    r_d.busy  = 1'b0;
                    r_d.err   = 1'b1;
                    r_d.ecode = ERR_ATTN_BUSY;
                end
            end
            S_ATTN: begin
                r_d.wr    = 1'b1;
                r_d.sel   = REG_ATTN;
                r_d.wdata = {8'h00, r_q.dev, r_q.atype};
                r_d.st    = S_IRQ_ON;
            end
            S_IRQ_ON: begin
                r_d.wr    = 1'b1;
                r_d.sel   = REG_CTRL;
                r_d.wdata = {8'h00, CTRL_IRQ_EN};
                if (r_q.atype == ATTN_CMD_REQ) begin
                    r_d.widx = '0;
                    r_d.st   = S_WORD;
                end else begin
                    r_d.st   = S_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end
            end
            S_WORD: begin
                r_d.wr    = 1'b1;
                r_d.sel   = REG_CMDW;
                r_d.wdata = r_q.words[r_q.widx];
                r_d.st    = S_SETTLE;
            end
            S_SETTLE: begin
                // write lands this cycle; full flag is valid next cycle
                r_d.st = S_POLL_FULL;
            end
            S_POLL_FULL: begin
                if (!cmd_full) begin
                    if (r_q.widx == last_idx) begin
                        r_d.st = S_WAIT_DONE;
                    end else begin
                        r_d.widx = r_q.widx + 1'b1;
                        r_d.st   = S_WORD;
                    end
                end else if (poll_last) begin
                    r_d.st    = S_IDLE;
                    r_d.busy  = 1'b0;
                    r_d.err   = 1'b1;
                    r_d.ecode = ERR_WORD_STUCK;
                end
            end
            S_WAIT_DONE: begin
                if (win_expired || (comp_valid && !comp_ok)) begin
                    r_d.st    = S_IDLE;
                    r_d.busy  = 1'b0;
                    r_d.err   = 1'b1;
                    r_d.ecode = ERR_COMPLETION;
                end else if (comp_valid) begin
                    r_d.st   = S_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign reg_wr    = r_q.wr;
    assign reg_sel   = r_q.sel;
    assign reg_wdata = r_q.wdata;
    assign busy      = r_q.busy;
    assign done      = r_q.done;
    assign err       = r_q.err;
    assign err_code  = r_q.ecode;
endmodule

// File: rtl/dsk_cmd_seq_chk.sv
module dsk_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       reg_wr,
    input logic [1:0] err_code
);
    // R11: a completion pulse never overlaps busy
    a_r11_pulse_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy);

    // R11: success and failure are exclusive
    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R11: busy only drops together with an outcome pulse
    a_r11_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || err));

    // R2: register writes belong to an operation
    a_r2_write_in_op: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (busy || done));

    // R9: a success pulse carries no error code, a failure always one
    a_r9_code_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (done |-> err_code == 2'd0) and (err |-> err_code != 2'd0));
endmodule

bind dsk_cmd_seq dsk_cmd_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .reg_wr  (reg_wr),
    .err_code(err_code)
);

// File: tb/dsk_cmd_seq_test.sv
module dsk_cmd_seq_test;
    localparam int POLL = 5;
    localparam int DIV  = 3;
    localparam int TCK  = 4;
    localparam int WIN  = DIV * TCK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        start = 1'b0;
    logic [4:0]  attn_type = 5'd1;
    logic        skip_busy = 1'b0;
    logic [2:0]  dev_num = '0;
    logic [4:0]  cmd_code = '0;
    logic [7:0]  opts = '0;
    logic        long_cmd = 1'b0;
    logic [15:0] arg1 = '0, arg2 = '0, arg3 = '0;
    logic        xfer_mode = 1'b0;
    logic [15:0] blk_count = '0;
    logic [9:0]  cyl = '0;
    logic [5:0]  head = '0;
    logic [4:0]  sector = '0;
    logic        reg_wr;
    logic [1:0]  reg_sel;
    logic [15:0] reg_wdata;
    logic        att_busy, cmd_full, comp_valid;
    logic        comp_ok = 1'b1;
    logic        busy, done, err;
    logic [1:0]  err_code;

    int busy_len = 0, full_len = 0, comp_dly = 0;
    bit comp_en = 1'b1;

    dsk_cmd_seq #(.POLL_LIMIT(POLL), .TICK_DIV(DIV), .TIMEOUT_TICKS(TCK)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .attn_type(attn_type),
        .skip_busy(skip_busy), .dev_num(dev_num), .cmd_code(cmd_code),
        .opts(opts), .long_cmd(long_cmd), .arg1(arg1), .arg2(arg2), .arg3(arg3),
        .xfer_mode(xfer_mode), .blk_count(blk_count), .cyl(cyl), .head(head),
        .sector(sector), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .att_busy(att_busy), .cmd_full(cmd_full), .comp_valid(comp_valid),
        .comp_ok(comp_ok), .busy(busy), .done(done), .err(err), .err_code(err_code)
    );

    // attachment model
    logic [15:0] cyc_q = 16'hFFFF, fcnt_q = '0, lw_q = 16'hFFFF;
    logic [17:0] lg [0:15];
    int nlog = 0;

    always @(posedge clk) begin
        if (start && !busy) cyc_q <= '0;
        else if (cyc_q != 16'hFFFF) cyc_q <= cyc_q + 1'b1;
        if (reg_wr && reg_sel == 2'd2) begin
            fcnt_q <= 16'(full_len);
            lw_q   <= '0;
        end else begin
            if (fcnt_q != 0) fcnt_q <= fcnt_q - 1'b1;
            if (lw_q != 16'hFFFF) lw_q <= lw_q + 1'b1;
        end
        if (start && !busy) nlog <= 0;
        else if (reg_wr) begin
            if (nlog < 16) lg[nlog] <= {reg_sel, reg_wdata};
            nlog <= nlog + 1;
        end
    end

    assign att_busy   = (cyc_q >= 16'd1) && (int'(cyc_q) <= busy_len);
    assign cmd_full   = (fcnt_q != 0);
    assign comp_valid = comp_en && (int'(lw_q) == full_len + 1 + comp_dly);

    int n_chk = 0, n_fail = 0;
    int cycles = 0;
    bit r_done, r_err;
    logic [1:0] r_code;
    int n_pulses;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] ew(int i);
        int w;
        bit four;
        four = xfer_mode || long_cmd;
        if (i == 0) begin
            w = (xfer_mode ? 2 : int'(opts)) * 256 + int'(dev_num) * 32 + int'(cmd_code);
            if (four) w = w | 16'h4000;
            return 16'(w);
        end
        if (xfer_mode) begin
            if (i == 1) return blk_count;
            if (i == 2) return 16'((int'(cyl) % 32) * 2048 + int'(head) * 32 + int'(sector));
            return 16'(int'(cyl) / 32);
        end
        if (i == 1) return arg1;
        if (i == 2) return arg2;
        return arg3;
    endfunction

    // run one operation; collects outcome and checks busy rose
    task automatic go(input string req);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11 busy after accept", busy, 1);
        r_done = 0; r_err = 0; r_code = 0;
        for (int k = 0; k < 400; k++) begin
            if (done || err) begin
                r_done = done; r_err = err; r_code = err_code;
                chk(busy == 1'b0, "R11 busy low at pulse", busy, 0);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        chk(!done && !err, "R11 one-cycle pulse", {done, err}, 0);
        repeat (2) @(negedge clk);
    endtask

    // compare the logged write stream; nw command words expected
    task automatic check_log(input string req, input int nw, input int n_hdr);
        chk(nlog == n_hdr + nw, req, nlog, n_hdr + nw);
        if (n_hdr >= 1) chk(lg[0] == 18'h00000, {req, " R2 ctrl off"}, lg[0], 0);
        if (n_hdr >= 2) chk(lg[1] == {2'd1, 8'h00, dev_num, attn_type}, {req, " R2 attn"},
                            lg[1], {2'd1, 8'h00, dev_num, attn_type});
        if (n_hdr >= 3) chk(lg[2] == 18'h00001, {req, " R2 ctrl on"}, lg[2], 1);
        for (int i = 0; i < nw; i++)
            chk(lg[3+i] == {2'd2, ew(i)}, {req, " word"}, lg[3+i], {2'd2, ew(i)});
    endtask

    task automatic defaults();
        attn_type = 5'd1; skip_busy = 0; long_cmd = 0; xfer_mode = 0;
        busy_len = 0; full_len = 0; comp_dly = 0; comp_en = 1; comp_ok = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && err == 0, "R1 outputs", {busy, done, err}, 0);
        chk(reg_wr == 0 && err_code == 0, "R1 bus/code", {reg_wr, err_code}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2/R6 sweep over device, length, code and options
        for (int d = 0; d < 8; d++)
            for (int l = 0; l < 2; l++)
                for (int c = 0; c < 4; c++)
                    for (int o = 0; o < 3; o++) begin
                        defaults();
                        dev_num  = 3'(d);
                        long_cmd = l[0];
                        cmd_code = (c == 0) ? 5'd0 : (c == 1) ? 5'd1 : (c == 2) ? 5'd18 : 5'd31;
                        opts     = (o == 0) ? 8'h00 : (o == 1) ? 8'hA5 : 8'hFF;
                        arg1 = 16'(16'h1100 + d * 7 + c);
                        arg2 = 16'(16'hBEEF ^ (o * 257));
                        arg3 = 16'(16'h0F00 + l * 3 + d);
                        go("R6");
                        chk(r_done && r_code == 0, "R6 done", {r_done, r_code}, 4);
                        check_log("R6", l ? 4 : 2, 3);
                    end

        // R7 transfer packing sweep
        for (int ci = 0; ci < 6; ci++)
            for (int hi = 0; hi < 3; hi++)
                for (int si = 0; si < 3; si++) begin
                    defaults();
                    xfer_mode = 1; dev_num = 3'(ci % 2); cmd_code = 5'(1 + si % 2);
                    opts = 8'h77;
                    cyl = (ci == 0) ? 10'd0 : (ci == 1) ? 10'd1 : (ci == 2) ? 10'd31 :
                          (ci == 3) ? 10'd32 : (ci == 4) ? 10'd1023 : 10'd682;
                    head = (hi == 0) ? 6'd0 : (hi == 1) ? 6'd17 : 6'd63;
                    sector = (si == 0) ? 5'd0 : (si == 1) ? 5'd9 : 5'd31;
                    blk_count = 16'(1 + ci * 40);
                    go("R7");
                    chk(r_done, "R7 done", r_done, 1);
                    check_log("R7", 4, 3);
                end

        // R5 non-command attention
        defaults(); xfer_mode = 0; attn_type = 5'd3; dev_num = 3'd5;
        go("R5");
        chk(r_done && r_code == 0, "R5 done", {r_done, r_code}, 4);
        check_log("R5", 0, 3);

        // R3 busy poll boundary
        defaults(); dev_num = 3'd2; busy_len = POLL - 1;
        go("R3");
        chk(r_done, "R3 tolerated busy", r_done, 1);
        check_log("R3", 2, 3);
        defaults(); dev_num = 3'd2; busy_len = POLL;
        go("R3");
        chk(r_err && r_code == 2'd1, "R3 busy timeout", {r_err, r_code}, 5);
        check_log("R3 no attn", 0, 1);

        // R4 skip busy poll
        defaults(); skip_busy = 1; busy_len = 60; dev_num = 3'd6;
        go("R4");
        chk(r_done, "R4 skip", r_done, 1);
        check_log("R4", 2, 3);

        // R8 word handshake boundary
        defaults(); long_cmd = 1; full_len = POLL - 1; dev_num = 3'd3;
        go("R8");
        chk(r_done, "R8 slow accept", r_done, 1);
        check_log("R8", 4, 3);
        defaults(); long_cmd = 1; full_len = POLL; dev_num = 3'd3;
        go("R8");
        chk(r_err && r_code == 2'd2, "R8 stuck", {r_err, r_code}, 6);
        check_log("R8 stop", 1, 3);

        // R9 completion status
        defaults(); comp_ok = 0; comp_dly = 2;
        go("R9");
        chk(r_err && r_code == 2'd3, "R9 failed status", {r_err, r_code}, 7);
        defaults(); comp_dly = 5;
        go("R9");
        chk(r_done && r_code == 0, "R9 ok status", {r_done, r_code}, 4);

        // R10 completion window
        defaults(); comp_dly = WIN - 1;
        go("R10");
        chk(r_done, "R10 last cycle", r_done, 1);
        defaults(); comp_dly = WIN;
        go("R10");
        chk(r_err && r_code == 2'd3, "R10 one late", {r_err, r_code}, 7);
        defaults(); comp_en = 0;
        go("R10");
        chk(r_err && r_code == 2'd3, "R10 none", {r_err, r_code}, 7);

        // R11 start ignored while busy
        defaults(); dev_num = 3'd1; busy_len = 3; cmd_code = 5'd9; opts = 8'h10;
        @(negedge clk); start = 1; @(negedge clk); start = 0;
        @(negedge clk); dev_num = 3'd7; start = 1; @(negedge clk); start = 0;
        n_pulses = 0;
        for (int k = 0; k < 80; k++) begin
            if (done || err) n_pulses++;
            @(negedge clk);
        end
        chk(n_pulses == 1, "R11 single outcome", n_pulses, 1);
        dev_num = 3'd1;
        check_log("R11 unchanged", 2, 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule